// File: doc/BRIEF.md
# Logical ALU with Status Flags

This unit carries out the bitwise operations AND, OR, XOR, NOT and TEST, together with two's-complement negation, on operands of a configurable width (8, 16 or 32 bits). A request is a single-cycle `inValid` strobe that comes with an opcode and two operands. On the next clock edge the unit registers the result, gives a one-cycle write-enable pulse when the operation has a result to keep, and updates a six-flag status register. Each flag in that register follows the update rule of the operation that ran.

The flags are carry, parity, half-carry (borrow out of bit 3), zero, sign and overflow. Five of them are presented as a packed status byte with fixed filler bits. Overflow has its own output. Parity always describes the least significant result byte, whatever the operand width.

Top module: `logic_alu`

## Requirements
- R1: Opcodes are AND=0, OR=1, XOR=2, NOT=3, TEST=4, NEG=5. For AND, OR and XOR, `resOut` holds the bitwise result of `opA` with `opB` on the clock edge after the strobe, and `resWe` is 1 in that cycle.
- R2: After AND, OR or XOR, carry, half-carry and overflow are 0. Sign is the result MSB. Zero is 1 exactly when the result is all zeros.
- R3: After any flag-writing operation, parity is 1 exactly when the low 8 bits of the result hold an even number of ones, for every operand width.
- R4: TEST updates sign, zero and parity as AND would, and clears carry, half-carry and overflow. It leaves `resOut` unchanged, and `resWe` stays 0.
- R5: NOT writes the bitwise inverse of `opA` to `resOut` with `resWe`=1. `opB` is ignored, and every flag, overflow included, keeps its value.
- R6: NEG writes zero minus `opA`. Carry is 0 when `opA` is zero and 1 otherwise. Sign, zero and parity follow the result.
- R7: After NEG, overflow is 1 only when `opA` is the most negative value (MSB set, all other bits clear). Half-carry is 1 exactly when `opA[3:0]` is nonzero.
- R8: `flagByte` bit 7 is sign, bit 6 zero, bit 4 half-carry, bit 2 parity and bit 0 carry. Bits 5 and 3 always read 0, and bit 1 always reads 1.
- R9: While `rstN` is low, `resOut` is 0, `resWe` is 0, `flagByte` is 8'h02 and `ovFlag` is 0.
- R10: A cycle with `inValid`=0, or with opcode 6 or 7, changes neither `resOut` nor any flag, and `resWe` is 0 after it.
- R11: `resWe` is high for exactly one cycle per writing request. It falls in the cycle after the last strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Request strobe |
| inOp | input | 3 | Operation code |
| opA | input | W | Destination operand |
| opB | input | W | Source operand |
| resOut | output | W | Registered result |
| resWe | output | 1 | Result write-enable pulse |
| flagByte | output | 8 | Packed status byte |
| ovFlag | output | 1 | Overflow flag |

## Verification
A chain of requests runs back to back, so every flag value also depends on the operation before it. A NOT that follows a NEG with overflow set shows whether flags are really held. A TEST after a NOT shows whether the result register is held. The negation operands are zero, one, a nibble-aligned value and the most negative value; together they separate the carry, overflow and half-carry rules. A second 16-bit instance takes results whose low byte and full word have different parity, or whose low byte is zero while the word is not, which catches parity taken over the wrong bits.

// File: rtl/lalu_pkg.sv
package lalu_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_XOR  = 3'd2,
    OP_NOT  = 3'd3,
    OP_TEST = 3'd4,
    OP_NEG  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } opT;

  // strobes from control to datapath
  typedef struct packed {
    logic wrRes;     // load result register and pulse write-enable
    logic updLogic;  // logic-class flag rule
    logic updNeg;    // negation flag rule
  } strobeT;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } flagsT;

endpackage

// File: rtl/lalu_ctrl.sv
module lalu_ctrl
  import lalu_pkg::*;
(
  input  logic       inValid,
  input  logic [2:0] inOp,
  output strobeT     stb,
  output opT         opSel
);

  always_comb begin
    opSel = opT'(inOp);
    stb   = '0;
    if (inValid) begin
      unique case (opSel)
        OP_AND, OP_OR, OP_XOR: begin
          stb.wrRes    = 1'b1;
          stb.updLogic = 1'b1;
        end
        OP_TEST: stb.updLogic = 1'b1;
        OP_NOT:  stb.wrRes    = 1'b1;
        OP_NEG: begin
          stb.wrRes  = 1'b1;
          stb.updNeg = 1'b1;
        end
        default: stb = '0;
      endcase
    end
  end

endmodule

// File: rtl/lalu_datapath.sv
module lalu_datapath
  import lalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobeT       stb,
  input  opT           opSel,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] resOut,
  output logic         resWe,
  output flagsT        flags
);

  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] rawRes;
  logic         rawPar;
  logic         rawZero;

  always_comb begin
    unique case (opSel)
      OP_AND, OP_TEST: rawRes = opA & opB;
      OP_OR:           rawRes = opA | opB;
      OP_XOR:          rawRes = opA ^ opB;
      OP_NOT:          rawRes = ~opA;
      OP_NEG:          rawRes = '0 - opA;
      default:         rawRes = '0;
    endcase
  end

  assign rawPar  = ~^rawRes[7:0];
  assign rawZero = (rawRes == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resOut <= '0;
      resWe  <= 1'b0;
      flags  <= '0;
    end else begin
      resWe <= stb.wrRes;
      if (stb.wrRes) resOut <= rawRes;
      if (stb.updLogic) begin
        flags.cf <= 1'b0;
        flags.of <= 1'b0;
        flags.af <= 1'b0;
        flags.pf <= rawPar;
        flags.zf <= rawZero;
        flags.sf <= rawRes[W-1];
      end else if (stb.updNeg) begin
        flags.cf <= (opA != '0);
        flags.of <= (opA == MIN_NEG);
        flags.af <= (opA[3:0] != 4'd0);
        flags.pf <= rawPar;
        flags.zf <= rawZero;
        flags.sf <= rawRes[W-1];
      end
    end
  end

endmodule

// File: rtl/logic_alu.sv
module logic_alu
  import lalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [2:0]   inOp,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] resOut,
  output logic         resWe,
  output logic [7:0]   flagByte,
  output logic         ovFlag
);

  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  strobeT stb;
  opT     opSel;
  flagsT  flags;

  lalu_ctrl u_ctrl (
    .inValid (inValid),
    .inOp    (inOp),
    .stb     (stb),
    .opSel   (opSel)
  );

  lalu_datapath #(.W(W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .opSel  (opSel),
    .opA    (opA),
    .opB    (opB),
    .resOut (resOut),
    .resWe  (resWe),
    .flags  (flags)
  );

  assign flagByte = {flags.sf, flags.zf, 1'b0, flags.af, 1'b0, flags.pf, 1'b1, flags.cf};
  assign ovFlag   = flags.of;

  a_r2_logic_clears: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp < 3'd3) |=> (!flagByte[0] && !flagByte[4] && !ovFlag));

  a_r4_test_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 3'd4) |=> (!resWe && $stable(resOut)));

  a_r5_not_keeps_flags: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 3'd3) |=> ($stable(flagByte) && $stable(ovFlag)));

  a_r6_neg_carry: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 3'd5) |=> (flagByte[0] == ($past(opA) != '0)));

  a_r7_neg_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 3'd5) |=> (ovFlag == ($past(opA) == MIN_NEG)));

  a_r10_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid || inOp > 3'd5) |=> (!resWe && $stable(resOut) && $stable(flagByte)));

endmodule

// File: tb/tb_logic_alu.sv
module tb_logic_alu;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] res;
    logic       we;
    logic [7:0] fb;
    logic       of;
  } vecT;

  // chained: each entry's flags follow from the one before
  localparam vecT TBL [NV] = '{
    '{3'd0, 8'h6D, 8'h3E, 8'h2C, 1'b1, 8'h02, 1'b0},  // AND
    '{3'd1, 8'h32, 8'hFF, 8'hFF, 1'b1, 8'h86, 1'b0},  // OR, sign+parity
    '{3'd2, 8'hA5, 8'hA5, 8'h00, 1'b1, 8'h46, 1'b0},  // XOR to zero
    '{3'd5, 8'h80, 8'h00, 8'h80, 1'b1, 8'h83, 1'b1},  // NEG most negative
    '{3'd3, 8'h96, 8'h00, 8'h69, 1'b1, 8'h83, 1'b1},  // NOT keeps flags
    '{3'd4, 8'hF3, 8'h81, 8'h69, 1'b0, 8'h86, 1'b0},  // TEST holds result
    '{3'd5, 8'h00, 8'h00, 8'h00, 1'b1, 8'h46, 1'b0},  // NEG zero
    '{3'd5, 8'h01, 8'h00, 8'hFF, 1'b1, 8'h97, 1'b0},  // NEG one
    '{3'd0, 8'h0F, 8'h07, 8'h07, 1'b1, 8'h02, 1'b0},  // AND clears CF/AF
    '{3'd6, 8'hFF, 8'hFF, 8'h07, 1'b0, 8'h02, 1'b0},  // reserved op
    '{3'd5, 8'h10, 8'h00, 8'hF0, 1'b1, 8'h87, 1'b0},  // NEG, no half borrow
    '{3'd3, 8'h00, 8'h5A, 8'hFF, 1'b1, 8'h87, 1'b0},  // NOT
    '{3'd7, 8'h00, 8'h00, 8'hFF, 1'b0, 8'h87, 1'b0},  // reserved op
    '{3'd2, 8'h3C, 8'h01, 8'h3D, 1'b1, 8'h02, 1'b0}   // XOR clears CF
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  inOp = '0;
  logic [7:0]  opA = '0, opB = '0;
  logic [7:0]  resOut;
  logic        resWe;
  logic [7:0]  flagByte;
  logic        ovFlag;

  logic        vW = 1'b0;
  logic [2:0]  opW = '0;
  logic [15:0] aW = '0, bW = '0;
  logic [15:0] resW;
  logic        weW;
  logic [7:0]  fbW;
  logic        ofW;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic_alu #(.W(8)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .opA(opA), .opB(opB),
    .resOut(resOut), .resWe(resWe), .flagByte(flagByte), .ovFlag(ovFlag)
  );

  logic_alu #(.W(16)) dutWide (
    .clk(clk), .rstN(rstN), .inValid(vW), .inOp(opW), .opA(aW), .opB(bW),
    .resOut(resW), .resWe(weW), .flagByte(fbW), .ovFlag(ofW)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd0, 3'd1, 3'd2: return "R1 R2 R3";
      3'd3:             return "R5";
      3'd4:             return "R4";
      3'd5:             return "R6 R7";
      default:          return "R10";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 result", resOut, 8'h00);
    chk("R9 we", resWe, 1'b0);
    chk("R9 R8 flag byte", flagByte, 8'h02);
    chk("R9 overflow", ovFlag, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      inValid = 1'b1;
      inOp = TBL[i].op;
      opA  = TBL[i].a;
      opB  = TBL[i].b;
      @(negedge clk);
      chk({tagOf(TBL[i].op), " result"}, resOut, TBL[i].res);
      chk({tagOf(TBL[i].op), " we"}, resWe, TBL[i].we);
      chk({tagOf(TBL[i].op), " R8 flag byte"}, flagByte, TBL[i].fb);
      chk({tagOf(TBL[i].op), " overflow"}, ovFlag, TBL[i].of);
    end

    // R11: write pulse drops after the strobe ends
    inValid = 1'b1; inOp = 3'd0; opA = 8'hF0; opB = 8'h3C;
    @(negedge clk);
    chk("R11 we high", resWe, 1'b1);
    chk("R1 result 30", resOut, 8'h30);
    inValid = 1'b0; inOp = 3'd5; opA = 8'hFF; opB = 8'hFF;
    @(negedge clk);
    chk("R11 we low", resWe, 1'b0);
    // R10: valid low with a NEG opcode presented changes nothing
    chk("R10 result held", resOut, 8'h30);
    chk("R10 flags held", flagByte, 8'h06);
    @(negedge clk);
    chk("R10 flags still held", flagByte, 8'h06);

    // R3: parity from the low byte only, 16-bit instance
    vW = 1'b1; opW = 3'd0; aW = 16'h0100; bW = 16'hFFFF;
    @(negedge clk);
    chk("R3 wide result", resW, 16'h0100);
    chk("R3 wide flags", fbW, 8'h06);
    opW = 3'd2; aW = 16'h8001; bW = 16'h0000;
    @(negedge clk);
    chk("R3 wide flags odd low byte", fbW, 8'h82);
    opW = 3'd5; aW = 16'h8000;
    @(negedge clk);
    chk("R7 wide overflow", ofW, 1'b1);
    chk("R6 wide result", resW, 16'h8000);
    vW = 1'b0;

    // R9: reset again clears flags
    rstN = 1'b0;
    @(negedge clk);
    chk("R9 reset clears", flagByte, 8'h02);
    chk("R9 reset result", resOut, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule